// File: doc/BRIEF.md
# Parallel-Load Serial Shift Register

This block is a byte-wide shift register that can either capture a whole parallel word in one clock or send its contents out one bit per clock. A shift/load select chooses between capturing the parallel word and shifting. A hold input stops shifting. A serial input feeds the first stage. The last stage drives the serial output, and a complemented copy of that output is also provided. Registers can be chained by connecting the serial output of one to the serial input of the next.

Every operation is sampled on the rising clock edge, so the whole block is synchronous. Priority runs from highest to lowest as follows:
- a synchronous active-high reset;
- the load select, which wins over the hold input;
- shifting, which takes place only when the hold input is low.

The first stage is parallel bit 0 and the last stage is parallel bit WIDTH-1. After a load, the highest parallel bit appears at the serial output first, followed by the lower bits in descending order.

Top module: `par_shift_reg`

## Requirements
- R1: When `rst` is high at a rising edge, every stage clears to 0 after that edge, whatever the other inputs are. Reset takes priority over loading.
- R2: When `shift_nload` is 0 (and `rst` is 0) at a rising edge, stage i takes `par_in[i]` after that edge. `ser_out` then shows `par_in[WIDTH-1]`.
- R3: A load still takes place when `clk_hold` is 1.
- R4: When `shift_nload` is 1 and `clk_hold` is 0, each edge moves stage i into stage i+1. After a load, `ser_out` shows `par_in[WIDTH-2]`, then the lower bits down to `par_in[0]`, one per such edge.
- R5: In shift mode, stage 0 takes `ser_in` at each enabled edge. A bit presented on `ser_in` reaches `ser_out` after WIDTH enabled edges.
- R6: When `shift_nload` is 1 and `clk_hold` is 1, all stages hold their values. This is confirmed by shifting the contents out afterwards.
- R7: `ser_out_n` is always the complement of `ser_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_nload | input | 1 | 1 = shift or hold, 0 = parallel load |
| clk_hold | input | 1 | 1 = hold in shift mode (ignored when loading) |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | WIDTH | Parallel word; bit i goes to stage i |
| ser_out | output | 1 | Last stage (WIDTH-1) |
| ser_out_n | output | 1 | Complement of last stage |

## Verification
Each result is due one clock edge after the stimulus that causes it, because `ser_out` comes straight from the last stage flop. The driver task applies the inputs at the falling edge and waits for the rising edge. Just after that edge, it pushes the expected serial output into a queue. The monitor pops each item a little later in the same cycle, so every comparison sees the value settled after exactly one edge. Bits loaded or shifted in are checked as they appear at the output over the following edges, which also shows that no bit was lost during hold cycles.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2,
        OP_HOLD  = 2'd3
    } shreg_op_e;

    typedef struct packed {
        logic rst;
        logic shift_nload;
        logic clk_hold;
    } shreg_ctl_t;

    // Priority: reset, then load, then shift unless held.
    function automatic shreg_op_e decode_op(input shreg_ctl_t c);
        if (c.rst)              return OP_CLEAR;
        else if (!c.shift_nload) return OP_LOAD;
        else if (c.clk_hold)    return OP_HOLD;
        else                    return OP_SHIFT;
    endfunction

    function automatic logic next_bit(input shreg_op_e op, input logic cur,
                                      input logic par, input logic prev);
        case (op)
            OP_CLEAR: return 1'b0;
            OP_LOAD:  return par;
            OP_SHIFT: return prev;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/shreg_ctrl.sv
module shreg_ctrl
    import shreg_pkg::*;
(
    input  logic      rst,
    input  logic      shift_nload,
    input  logic      clk_hold,
    output shreg_op_e op
);
    shreg_ctl_t ctl;

    always_comb begin
        ctl.rst         = rst;
        ctl.shift_nload = shift_nload;
        ctl.clk_hold    = clk_hold;
        op              = decode_op(ctl);
    end
endmodule

// File: rtl/shreg_cell.sv
module shreg_cell
    import shreg_pkg::*;
(
    input  logic      clk,
    input  shreg_op_e op,
    input  logic      par_bit,
    input  logic      prev_bit,
    output logic      q
);
    always_ff @(posedge clk) begin
        q <= next_bit(op, q, par_bit, prev_bit);
    end
endmodule

// File: rtl/shreg_outdrv.sv
module shreg_outdrv (
    input  logic last_stage,
    output logic true_out,
    output logic comp_out
);
    always_comb begin
        true_out = last_stage;
        comp_out = ~last_stage;
    end
endmodule

// File: rtl/par_shift_reg.sv
module par_shift_reg
    import shreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_nload,
    input  logic             clk_hold,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out,
    output logic             ser_out_n
);
    localparam int LAST = WIDTH - 1;

    shreg_op_e        op;
    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] feed;

    shreg_ctrl u_ctrl (
        .rst         (rst),
        .shift_nload (shift_nload),
        .clk_hold    (clk_hold),
        .op          (op)
    );

    assign feed = {stage_q[WIDTH-2:0], ser_in};

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        shreg_cell u_cell (
            .clk      (clk),
            .op       (op),
            .par_bit  (par_in[i]),
            .prev_bit (feed[i]),
            .q        (stage_q[i])
        );
    end

    shreg_outdrv u_out (
        .last_stage (stage_q[LAST]),
        .true_out   (ser_out),
        .comp_out   (ser_out_n)
    );
endmodule

// File: rtl/par_shift_reg_chk.sv
module par_shift_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             shift_nload,
    input logic             clk_hold,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] stages,
    input logic             ser_out,
    input logic             ser_out_n
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (stages == '0)); // R1
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        !shift_nload |=> (stages == $past(par_in)) && (ser_out == $past(par_in[WIDTH-1]))); // R2
    AST_LOAD_OVER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!shift_nload && clk_hold) |=> (stages == $past(par_in))); // R3
    AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (rst)
        (shift_nload && !clk_hold) |=> (ser_out == $past(stages[WIDTH-2]))); // R4
    AST_SERIAL_FILL: assert property (@(posedge clk) disable iff (rst)
        (shift_nload && !clk_hold) |=> (stages[0] == $past(ser_in))); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (shift_nload && clk_hold) |=> $stable(stages)); // R6
    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        ser_out_n == ~ser_out); // R7
endmodule

bind par_shift_reg par_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .shift_nload (shift_nload),
    .clk_hold    (clk_hold),
    .ser_in      (ser_in),
    .par_in      (par_in),
    .stages      (stage_q),
    .ser_out     (ser_out),
    .ser_out_n   (ser_out_n)
);

// File: tb/par_shift_reg_test.sv
`timescale 1ns/100ps
module par_shift_reg_test;
    localparam int WIDTH = 8;

    typedef struct {
        logic  val;
        string req;
    } item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             shift_nload = 1'b0;
    logic             clk_hold = 1'b0;
    logic             ser_in = 1'b0;
    logic [WIDTH-1:0] par_in = '0;
    logic             ser_out;
    logic             ser_out_n;

    int checks = 0;
    int errors = 0;
    item_t q[$];
    logic [WIDTH-1:0] mdl = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    par_shift_reg #(.WIDTH(WIDTH)) uut (
        .clk(clk), .rst(rst), .shift_nload(shift_nload), .clk_hold(clk_hold),
        .ser_in(ser_in), .par_in(par_in), .ser_out(ser_out), .ser_out_n(ser_out_n)
    );

    // Driver: one clock of stimulus, expected output pushed after the edge.
    task automatic step(input logic r, input logic snl, input logic h,
                        input logic si, input logic [WIDTH-1:0] p, input string tag);
        item_t it;
        @(negedge clk);
        rst = r; shift_nload = snl; clk_hold = h; ser_in = si; par_in = p;
        if (r)         mdl = '0;
        else if (!snl) mdl = p;
        else if (!h)   mdl = {mdl[WIDTH-2:0], si};
        @(posedge clk);
        #0.5;
        it.val = mdl[WIDTH-1];
        it.req = tag;
        q.push_back(it);
    endtask

    // Monitor: compares each result one edge after its stimulus.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (ser_out !== it.val) begin
                errors++;
                $display("FAIL %s: ser_out=%b expected %b", it.req, ser_out, it.val);
            end
            checks++;
            if (ser_out_n !== ~it.val) begin
                errors++;
                $display("FAIL R7: ser_out_n=%b expected %b", ser_out_n, ~it.val);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset clears, even while load requested
        step(1, 0, 0, 1, 8'hFF, "R1");
        step(1, 0, 0, 1, 8'hFF, "R1");
        // R2 load then R4 shift-out order
        step(0, 0, 0, 0, 8'hB4, "R2");
        for (int i = 0; i < WIDTH - 1; i++) step(0, 1, 0, 0, 8'h00, "R4");
        // R3 load with hold asserted
        step(0, 0, 1, 0, 8'h5A, "R3");
        step(0, 1, 0, 0, 8'h00, "R4");
        // R6 hold in shift mode, then shift rest out to confirm contents
        for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 8'hFF, "R6");
        for (int i = 0; i < WIDTH - 2; i++) step(0, 1, 0, 0, 8'h00, "R6");
        // R5 serial fill: push pattern, then flush it out
        for (int i = 0; i < WIDTH; i++) step(0, 1, 0, ((8'hC9 >> i) & 1) != 0, 8'h00, "R5");
        for (int i = 0; i < WIDTH; i++) step(0, 1, 0, 1'b0, 8'h00, "R5");
        // R4 second pattern, mixed with hold cycles
        step(0, 0, 0, 0, 8'h96, "R2");
        for (int i = 0; i < WIDTH - 1; i++) begin
            step(0, 1, 1, 1, 8'h00, "R6");
            step(0, 1, 0, 1, 8'h00, "R4");
        end
        // R1 reset mid-stream
        step(0, 0, 0, 0, 8'hFF, "R2");
        step(1, 1, 0, 1, 8'hFF, "R1");
        step(0, 1, 1, 1, 8'hFF, "R6");
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule